// File: doc/BRIEF.md
# Pin-Sequence Mode Key Detector

This block watches two control pins of a serial LED sink driver, the latch strobe and the active-low output enable, on every rising clock edge. It recognises two fixed five-edge key patterns on those pins. One key moves the driver from normal operation into diagnostic (error-detection) mode. The other key brings it back to normal operation. The pins keep their ordinary latch and enable meaning at all times. This block only adds the mode switch on top of them.

The result is a level flag that tells the shift data path which mode applies. There is also a one-cycle pulse for each direction of change, so that the data path can line up its first sampled serial bit with the edge after the key. The two keys must alternate. A key that repeats the current mode is ignored. Partial or corrupted sequences are ignored too. Recognition slides over a running five-sample window, so a key may begin on any edge.

Top module: `keyseq_mode_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces the mode flag to 0 (normal) and both pulses to 0, and it clears the sample history, so that key edges seen before reset never count towards a key after reset.
- R2: In normal mode, the enter key is oe_i = 1,0,1,1,1 together with le_i = 0,0,0,1,0 on five consecutive rising edges (first edge first). It sets mode_o to 1 in the cycle right after the fifth edge, so the sixth edge is the first one seen in diagnostic mode.
- R3: In diagnostic mode, the leave key is oe_i = 1,0,1,1,1 with le_i = 0 on all five edges. It clears mode_o to 0 in the cycle right after the fifth edge.
- R4: enter_o is high for exactly the one cycle after the fifth edge of an accepted enter key. leave_o is high for exactly the one cycle after the fifth edge of an accepted leave key. In any other cycle each is 0.
- R5: An enter key that completes while mode_o is 1 has no effect: mode_o stays 1 and no pulse appears.
- R6: A leave key that completes while mode_o is 0 has no effect: mode_o stays 0 and no pulse appears.
- R7: Any sequence that is not a full enter or leave key leaves mode_o and both pulses unchanged. This includes a key cut short, or a key with one wrong oe_i or le_i value.
- R8: Matching slides edge by edge. A key is accepted whatever edges came before it, including an aborted key prefix. The last edge of one key may also serve as the first edge of the next key.
- R9: enter_o and leave_o are never high together, and mode_o changes only in a cycle in which the matching pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock. Pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| le_i | input | 1 | Latch strobe pin level |
| oe_i | input | 1 | Output-enable pin level (active low in normal use) |
| mode_o | output | 1 | 1 = diagnostic mode, 0 = normal mode |
| enter_o | output | 1 | One-cycle pulse on entry into diagnostic mode |
| leave_o | output | 1 | One-cycle pulse on return to normal mode |

## Verification
Two functions can meet on the same edge: a key completes and changes the mode, and the same sample also opens the next key in the sliding window. The bench provokes this by driving an enter key whose fifth edge is also the first edge of a leave key, so only nine edges in total are needed for the round trip. A reference model in the bench keeps its own five-sample histories and predicts the mode flag and both pulses after every edge. The flag must rise after edge five and fall after edge nine, with exactly one pulse of each kind. The same model judges repeated keys, aborted prefixes, and keys cut by reset.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

  localparam int KEY_LEN_DEF = 5;

  // Oldest sample in the MSB, newest sample in the LSB.
  localparam logic [KEY_LEN_DEF-1:0] OE_KEY_DEF   = 5'b10111;
  localparam logic [KEY_LEN_DEF-1:0] ENTER_LE_DEF = 5'b00010;
  localparam logic [KEY_LEN_DEF-1:0] LEAVE_LE_DEF = 5'b00000;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_DIAG   = 1'b1
  } op_mode_e;

endpackage

// File: rtl/keyseq_history.sv
module keyseq_history #(
  parameter int WIN = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_i,
  output logic [WIN-1:0] window_o
);
  localparam int HIST = WIN - 1;

  logic [HIST-1:0] hist_q;

  // The window the current edge sees: the stored samples plus the pin level now.
  function automatic logic [WIN-1:0] slide(input logic [HIST-1:0] h, input logic b);
    return {h, b};
  endfunction

  assign window_o = slide(hist_q, sample_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= window_o[HIST-1:0];
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hist_q[0] == $past(sample_i)) else $error("history shift"); // R8

endmodule

// File: rtl/keyseq_matcher.sv
module keyseq_matcher #(
  parameter int             WIN    = 5,
  parameter logic [WIN-1:0] KEY_OE = '0,
  parameter logic [WIN-1:0] KEY_LE = '0
) (
  input  logic [WIN-1:0] oe_win_i,
  input  logic [WIN-1:0] le_win_i,
  output logic           hit_o
);
  function automatic logic key_eq(input logic [WIN-1:0] w, input logic [WIN-1:0] k);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WIN; i++) ok = ok & (w[i] == k[i]);
    return ok;
  endfunction

  assign hit_o = key_eq(oe_win_i, KEY_OE) & key_eq(le_win_i, KEY_LE);

endmodule

// File: rtl/keyseq_mode_fsm.sv
module keyseq_mode_fsm
  import keyseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_enter_i,
  input  logic hit_leave_i,
  output logic mode_o,
  output logic enter_o,
  output logic leave_o
);
  op_mode_e mode_q;
  logic     go_enter;
  logic     go_leave;

  assign go_enter = (mode_q == MODE_NORMAL) && hit_enter_i;
  assign go_leave = (mode_q == MODE_DIAG)   && hit_leave_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      enter_o <= 1'b0;
      leave_o <= 1'b0;
    end else begin
      enter_o <= go_enter;
      leave_o <= go_leave;
      if (go_enter)      mode_q <= MODE_DIAG;
      else if (go_leave) mode_q <= MODE_NORMAL;
    end
  end

  assign mode_o = (mode_q == MODE_DIAG);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_o && leave_o)) else $error("both pulses"); // R9
  AST_RISE_NEEDS_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o) |-> enter_o) else $error("rise w/o pulse"); // R2
  AST_FALL_NEEDS_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_o) |-> leave_o) else $error("fall w/o pulse"); // R3
  AST_ENTER_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |=> !enter_o) else $error("enter pulse long"); // R4
  AST_LEAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    leave_o |=> !leave_o) else $error("leave pulse long"); // R4
  AST_REPEAT_ENTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o && hit_enter_i) |=> (mode_o && !enter_o)) else $error("repeat enter"); // R5
  AST_REPEAT_LEAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && hit_leave_i) |=> (!mode_o && !leave_o)) else $error("repeat leave"); // R6
  AST_KEYS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_enter_i && hit_leave_i)) else $error("keys overlap"); // R7

endmodule

// File: rtl/keyseq_mode_ctrl.sv
module keyseq_mode_ctrl
  import keyseq_pkg::*;
#(
  parameter int                 KEY_LEN  = KEY_LEN_DEF,
  parameter logic [KEY_LEN-1:0] OE_KEY   = OE_KEY_DEF,
  parameter logic [KEY_LEN-1:0] ENTER_LE = ENTER_LE_DEF,
  parameter logic [KEY_LEN-1:0] LEAVE_LE = LEAVE_LE_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic le_i,
  input  logic oe_i,
  output logic mode_o,
  output logic enter_o,
  output logic leave_o
);
  localparam int NKEYS = 2;
  localparam logic [NKEYS*KEY_LEN-1:0] LE_KEYS = {LEAVE_LE, ENTER_LE};

  logic [KEY_LEN-1:0] oe_win;
  logic [KEY_LEN-1:0] le_win;
  logic [NKEYS-1:0]   key_hit;  // [0] enter, [1] leave

  keyseq_history #(.WIN(KEY_LEN)) u_oe_hist (
    .clk(clk), .rst_n(rst_n), .sample_i(oe_i), .window_o(oe_win));

  keyseq_history #(.WIN(KEY_LEN)) u_le_hist (
    .clk(clk), .rst_n(rst_n), .sample_i(le_i), .window_o(le_win));

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    keyseq_matcher #(
      .WIN   (KEY_LEN),
      .KEY_OE(OE_KEY),
      .KEY_LE(LE_KEYS[k*KEY_LEN +: KEY_LEN])
    ) u_match (
      .oe_win_i(oe_win), .le_win_i(le_win), .hit_o(key_hit[k]));
  end

  keyseq_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .hit_enter_i(key_hit[0]), .hit_leave_i(key_hit[1]),
    .mode_o(mode_o), .enter_o(enter_o), .leave_o(leave_o));

  AST_ENTER_MODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> mode_o) else $error("enter w/o mode"); // R4
  AST_LEAVE_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    leave_o |-> !mode_o) else $error("leave with mode"); // R4

endmodule

// File: tb/keyseq_mode_ctrl_test.sv
module keyseq_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic le_i = 1'b0;
  logic oe_i = 1'b1;
  logic mode_o, enter_o, leave_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  keyseq_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .le_i(le_i), .oe_i(oe_i),
    .mode_o(mode_o), .enter_o(enter_o), .leave_o(leave_o));

  typedef struct {
    logic  mode;
    logic  en;
    logic  lv;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  // Reference model built from the requirement text
  logic [4:0] m_oe = '0, m_le = '0;
  logic m_mode = 1'b0;

  task automatic model_reset();
    m_oe = '0; m_le = '0; m_mode = 1'b0;
  endtask

  task automatic step(input logic oe, input logic le, input string tag);
    exp_t e;
    logic ent, lv;
    @(negedge clk);
    oe_i = oe; le_i = le;
    m_oe = {m_oe[3:0], oe};
    m_le = {m_le[3:0], le};
    ent = !m_mode && (m_oe == 5'b10111) && (m_le == 5'b00010);
    lv  =  m_mode && (m_oe == 5'b10111) && (m_le == 5'b00000);
    if (ent) m_mode = 1'b1;
    if (lv)  m_mode = 1'b0;
    e.mode = m_mode; e.en = ent; e.lv = lv; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic send_key(input logic [4:0] oe, input logic [4:0] le, input string tag);
    for (int i = 4; i >= 0; i--) step(oe[i], le[i], tag);
  endtask

  task automatic check_now(input string tag, input logic em, input logic ee, input logic el);
    checks++;
    if (mode_o !== em || enter_o !== ee || leave_o !== el) begin
      errors++;
      $display("FAIL %s actual mode=%b enter=%b leave=%b expected mode=%b enter=%b leave=%b",
               tag, mode_o, enter_o, leave_o, em, ee, el);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #5;
    check_now(tag, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compares after each driven edge, mid high phase
  always @(posedge clk) begin
    #5;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check_now(e.tag, e.mode, e.en, e.lv);
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    check_now("R1 reset state", 1'b0, 1'b0, 1'b0);
    do_reset("R1 reset state");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R7 idle");
    send_key(5'b10111, 5'b00010, "R2 R4 enter key");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R2 diag hold");
    send_key(5'b10111, 5'b00010, "R5 repeated enter");
    send_key(5'b10111, 5'b00000, "R3 R4 leave key");
    send_key(5'b10111, 5'b00000, "R6 repeated leave");
    // aborted enter: four good edges then wrong oe
    send_key(5'b10110, 5'b00010, "R7 cut enter");
    // wrong le on the fourth edge
    send_key(5'b10111, 5'b00000, "R7 wrong le");
    send_key(5'b10111, 5'b01010, "R7 extra le");
    // prefix 1,0 then a full enter key
    step(1'b1, 1'b0, "R8 prefix");
    step(1'b0, 1'b0, "R8 prefix");
    send_key(5'b10111, 5'b00010, "R8 slid enter");
    // leave key sharing the last enter edge
    for (int i = 0; i < 4; i++) step((i == 0) ? 1'b0 : 1'b1, 1'b0, "R8 R9 shared edge leave");
    step(1'b1, 1'b0, "R9 after leave");
    // R1: history cleared by reset
    for (int i = 4; i >= 1; i--) step(5'b10111 >> i, 5'b00010 >> i, "R1 pre-reset part");
    do_reset("R1 reset mid key");
    step(1'b1, 1'b0, "R1 no stale key");
    step(1'b1, 1'b1, "R1 no stale key");
    // reset out of diag mode
    send_key(5'b10111, 5'b00010, "R2 enter again");
    do_reset("R1 reset in diag");
    step(1'b1, 1'b0, "R1 normal after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule